// File: doc/BRIEF.md
# VLAN Tag Inserter

This block sits on the transmit path between a frame source and the Ethernet MAC. Both sides are byte-wide streams with valid/ready handshakes. When tagging is enabled for a frame, the block places a four-byte 802.1Q tag after the two MAC addresses, which are the first twelve bytes. The original Ethertype and payload follow the tag unchanged. The tag is the tag Ethertype followed by a 16-bit control word. The control word carries priority, the canonical format bit and the VLAN identifier.

The tag Ethertype always comes from a 32-bit default register. It is normally 0x8100, but other values are allowed. The control word comes from a per-frame sideband value when the source flags one with the first byte of the frame. Otherwise it comes from the same register. Software writes the register through a single-cycle write port. A write that would set the Ethertype to the reserved control value 0x8808 is refused, and the whole register keeps its previous contents.

While the four tag bytes are sent, the block holds the source off, so no input byte is lost or repeated. The block adds no storage on the data path. Input bytes pass straight through to the output, and the output's ready drives the input's ready.

Top module: `vtag_inserter`

## Requirements
- R1: After reset, every field of the default register is zero, no frame is in progress and m_tvalid is low while s_tvalid is low. A tagged frame sent before any write therefore carries four zero tag bytes.
- R2: A frame whose first byte is accepted while tag_enable is low comes out byte for byte identical to its input.
- R3: In a tagged frame longer than HDR_BYTES (12) bytes, the four tag bytes follow input byte HDR_BYTES. All input bytes then follow in their original order, and the frame grows by exactly four bytes.
- R4: Register layout: cfg_wr_data[31:16] is the tag Ethertype, [15:13] the priority, [12] the canonical format bit and [11:0] the VLAN ID. The tag bytes go out in the order Ethertype[15:8], Ethertype[7:0], control[15:8], control[7:0]. The control word is {priority, CFI, VID}.
- R5: When s_tag_valid is high with the first byte of a frame, s_tag_tci is used as the control word, and the Ethertype still comes from the register.
- R6: A write whose bits [31:16] equal 0x8808 is refused, and all 32 register bits keep their previous values.
- R7: Any Ethertype other than 0x8808, for example 0x88A8, is accepted and inserted as written.
- R8: A VID of zero does not suppress the tag: priority and CFI are inserted as written.
- R9: s_tready is low in every cycle in which a tag byte is offered. A tag byte held against a low m_tready stays on m_tdata until it is taken.
- R10: A tagged frame of HDR_BYTES bytes or fewer passes through unmodified.
- R11: tag_enable, s_tag_valid, s_tag_tci and the register contents are sampled when the first byte of a frame is accepted. Later changes, including register writes, have no effect on that frame.
- R12: m_tlast is high only on the byte that carried s_tlast and never on a tag byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the default register |
| cfg_wr_data | input | 32 | Default register write value (Ethertype, priority, CFI, VID) |
| tag_enable | input | 1 | Tag this frame; sampled with its first byte |
| s_tdata | input | 8 | Input stream byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tlast | input | 1 | Input byte ends the frame |
| s_tag_valid | input | 1 | Per-frame control word present; sampled with first byte |
| s_tag_tci | input | 16 | Per-frame control word |
| s_tready | output | 1 | Block accepts the input byte |
| m_tdata | output | 8 | Output stream byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tlast | output | 1 | Output byte ends the frame |
| m_tready | input | 1 | Downstream accepts the output byte |

## Verification
The bench builds the block with HDR_BYTES at 12 and PER_FRAME_EN set. This puts the real header offset under test, including frames of exactly 12 and 13 bytes, and it enables the per-frame control-word path. Random gaps on the input side and random stalls on the output side let tag bytes meet a stalled sink. One frame rewrites the register and flips the sideband inputs after its first byte, which tests the sampling point.

// File: rtl/vtag_pkg.sv
package vtag_pkg;

   // Default register word; the bit layout is visible to software.
   typedef struct packed {
      logic [15:0] etype;
      logic [2:0]  pri;
      logic        cfi;
      logic [11:0] vid;
   } vtag_word_t;

   localparam int unsigned TAG_BYTES = $bits(vtag_word_t) / 8;

   function automatic logic [15:0] tci_of(vtag_word_t w);
      return {w.pri, w.cfi, w.vid};
   endfunction

endpackage

// File: rtl/vtag_dflt_reg.sv
module vtag_dflt_reg
   import vtag_pkg::*;
#(
   parameter logic [15:0] RSVD_TYPE = 16'h8808
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   output vtag_word_t  dflt_q
);

   vtag_word_t wr_word;
   logic       wr_legal;

   assign wr_word  = vtag_word_t'(wr_data);
   assign wr_legal = (wr_word.etype != RSVD_TYPE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dflt_q <= '0;
      end else if (wr_en && wr_legal) begin
         dflt_q <= wr_word;
      end
   end

   AST_RSVD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[31:16] == RSVD_TYPE) |=> (dflt_q == $past(dflt_q))); // R6
   AST_WR_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[31:16] != RSVD_TYPE) |=> (dflt_q == $past(wr_data))); // R7

endmodule

// File: rtl/vtag_tag_sel.sv
module vtag_tag_sel
   import vtag_pkg::*;
#(
   parameter bit PER_FRAME_EN = 1'b1
) (
   input  vtag_word_t  dflt,
   input  logic        frm_valid,
   input  logic [15:0] frm_tci,
   output vtag_word_t  word
);

   generate
      if (PER_FRAME_EN) begin : g_frame
         // The Ethertype always comes from the register; only the control word may be replaced.
         always_comb begin
            word = dflt;
            if (frm_valid) begin
               {word.pri, word.cfi, word.vid} = frm_tci;
            end
         end
      end else begin : g_dflt_only
         logic unused_sideband;
         assign unused_sideband = ^{frm_valid, frm_tci};
         assign word = dflt;
      end
   endgenerate

endmodule

// File: rtl/vtag_stream_ctrl.sv
module vtag_stream_ctrl
   import vtag_pkg::*;
#(
   parameter int unsigned HDR_BYTES = 12,
   parameter int unsigned DATA_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tag_en_in,
   input  vtag_word_t        tag_word_in,
   input  logic [DATA_W-1:0] s_tdata,
   input  logic              s_tvalid,
   input  logic              s_tlast,
   output logic              s_tready,
   output logic [DATA_W-1:0] m_tdata,
   output logic              m_tvalid,
   output logic              m_tlast,
   input  logic              m_tready
);

   localparam int unsigned CNT_W = $clog2(HDR_BYTES + 1);
   localparam int unsigned IDX_W = (TAG_BYTES > 1) ? $clog2(TAG_BYTES) : 1;
   localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BYTES - 1);
   localparam logic [CNT_W-1:0] HDR_FULL = CNT_W'(HDR_BYTES);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TAG_BYTES - 1);

   logic             in_frame;
   logic [CNT_W-1:0] hdr_cnt;
   logic             ins_act;
   logic [IDX_W-1:0] ins_idx;
   logic             frm_en;
   vtag_word_t       frm_word;
   logic             s_acc;
   logic             first_byte;
   logic             en_now;
   logic [7:0]       tag_byte;

   assign first_byte = !in_frame;
   assign en_now     = first_byte ? tag_en_in : frm_en;
   assign s_acc      = s_tvalid && s_tready;

   // Tag bytes go out most significant byte first (R4).
   assign tag_byte = frm_word[(TAG_BYTES - 1 - int'(ins_idx)) * 8 +: 8];

   // Source is held off while tag bytes go out (R9).
   assign s_tready = !ins_act && m_tready;
   assign m_tvalid = ins_act || s_tvalid;
   assign m_tdata  = ins_act ? DATA_W'(tag_byte) : s_tdata;
   assign m_tlast  = !ins_act && s_tlast;   // R12

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         hdr_cnt  <= '0;
         ins_act  <= 1'b0;
         ins_idx  <= '0;
         frm_en   <= 1'b0;
         frm_word <= '0;
      end else begin
         if (s_acc) begin
            if (first_byte) begin
               // Frame-level settings are sampled here (R11).
               frm_en   <= tag_en_in;
               frm_word <= tag_word_in;
            end
            if (s_tlast) begin
               in_frame <= 1'b0;
               hdr_cnt  <= '0;
            end else begin
               in_frame <= 1'b1;
               if (hdr_cnt != HDR_FULL) begin
                  hdr_cnt <= hdr_cnt + 1'b1;
               end
               // Insertion only when more bytes follow the header (R3, R10).
               if (hdr_cnt == HDR_LAST && en_now) begin
                  ins_act <= 1'b1;
                  ins_idx <= '0;
               end
            end
         end
         if (ins_act && m_tready) begin
            ins_idx <= ins_idx + 1'b1;
            if (ins_idx == IDX_LAST) begin
               ins_act <= 1'b0;
            end
         end
      end
   end

   AST_INSERT_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ins_act) |-> (hdr_cnt == HDR_FULL && $past(s_acc))); // R3
   AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_act && !m_tready) |=> (ins_act && $stable(m_tdata))); // R9
   AST_TAG_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ins_act) |-> ($past(ins_idx) == IDX_LAST && $past(m_tready))); // R3
   AST_NO_SRC_IN_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      ins_act |=> !($past(s_acc))); // R9

endmodule

// File: rtl/vtag_inserter.sv
module vtag_inserter
   import vtag_pkg::*;
#(
   parameter int unsigned HDR_BYTES    = 12,
   parameter int unsigned DATA_W       = 8,
   parameter bit          PER_FRAME_EN = 1'b1,
   parameter logic [15:0] RSVD_TYPE    = 16'h8808
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [31:0]       cfg_wr_data,
   input  logic              tag_enable,
   input  logic [DATA_W-1:0] s_tdata,
   input  logic              s_tvalid,
   input  logic              s_tlast,
   input  logic              s_tag_valid,
   input  logic [15:0]       s_tag_tci,
   output logic              s_tready,
   output logic [DATA_W-1:0] m_tdata,
   output logic              m_tvalid,
   output logic              m_tlast,
   input  logic              m_tready
);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("vtag_inserter: DATA_W must be 8");
      end
      if (HDR_BYTES < 1) begin : g_bad_hdr
         $error("vtag_inserter: HDR_BYTES must be at least 1");
      end
   endgenerate

   vtag_word_t dflt_q;
   vtag_word_t sel_word;

   vtag_dflt_reg #(.RSVD_TYPE(RSVD_TYPE)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_data (cfg_wr_data),
      .dflt_q  (dflt_q)
   );

   vtag_tag_sel #(.PER_FRAME_EN(PER_FRAME_EN)) u_sel (
      .dflt      (dflt_q),
      .frm_valid (s_tag_valid),
      .frm_tci   (s_tag_tci),
      .word      (sel_word)
   );

   vtag_stream_ctrl #(.HDR_BYTES(HDR_BYTES), .DATA_W(DATA_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .tag_en_in   (tag_enable),
      .tag_word_in (sel_word),
      .s_tdata     (s_tdata),
      .s_tvalid    (s_tvalid),
      .s_tlast     (s_tlast),
      .s_tready    (s_tready),
      .m_tdata     (m_tdata),
      .m_tvalid    (m_tvalid),
      .m_tlast     (m_tlast),
      .m_tready    (m_tready)
   );

endmodule

// File: tb/vtag_inserter_test.sv
`timescale 1ns/100ps
module vtag_inserter_test;

   localparam int HDR = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [31:0] cfg_wr_data = '0;
   logic        tag_enable = 1'b0;
   logic [7:0]  s_tdata = '0;
   logic        s_tvalid = 1'b0;
   logic        s_tlast = 1'b0;
   logic        s_tag_valid = 1'b0;
   logic [15:0] s_tag_tci = '0;
   logic        s_tready;
   logic [7:0]  m_tdata;
   logic        m_tvalid;
   logic        m_tlast;
   logic        m_tready = 1'b1;

   vtag_inserter #(.HDR_BYTES(HDR), .DATA_W(8), .PER_FRAME_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
      .tag_enable(tag_enable), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
      .s_tag_valid(s_tag_valid), .s_tag_tci(s_tag_tci), .s_tready(s_tready),
      .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;
   bit running = 1'b0;
   bit sink_rand = 1'b0;

   logic [7:0] exp_d[$];
   logic       exp_l[$];
   logic       exp_t[$];
   string      exp_r[$];
   logic [15:0] cur_type = 16'h0000;   // R1: register starts at zero
   logic [15:0] cur_tci  = 16'h0000;

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(int seed, int i);
      return 8'(seed + i * 7);
   endfunction

   task automatic model_frame(int len, bit en, bit pv, logic [15:0] ptci, int seed,
                              string treq, string breq);
      logic [31:0] w;
      w = {cur_type, (pv ? ptci : cur_tci)};
      for (int i = 0; i < len; i++) begin
         if (en && len > HDR && i == HDR) begin
            for (int k = 0; k < 4; k++) begin
               exp_d.push_back(w[31 - 8 * k -: 8]);
               exp_l.push_back(1'b0);
               exp_t.push_back(1'b1);
               exp_r.push_back(treq);
            end
         end
         exp_d.push_back(pat(seed, i));
         exp_l.push_back(i == len - 1);
         exp_t.push_back(1'b0);
         exp_r.push_back(breq);
      end
   endtask

   task automatic note_write(logic [31:0] v);
      if (v[31:16] != 16'h8808) begin   // R6 reserved type is refused
         cur_type = v[31:16];
         cur_tci  = v[15:0];
      end
   endtask

   task automatic cfg_write(logic [31:0] v);
      @(negedge clk);
      cfg_wr_en = 1'b1;
      cfg_wr_data = v;
      note_write(v);
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic send_frame(int len, bit en, bit pv, logic [15:0] ptci, int seed,
                             string treq, string breq, bit mid, logic [31:0] midw);
      int  i;
      bit  pres;
      bit  midd;
      model_frame(len, en, pv, ptci, seed, treq, breq);
      i = 0; pres = 1'b0; midd = 1'b0;
      while (i < len) begin
         @(negedge clk);
         cfg_wr_en = 1'b0;
         if (mid && i == 1 && !midd) begin
            // R11: change everything after the first byte was taken
            midd = 1'b1;
            cfg_wr_en = 1'b1;
            cfg_wr_data = midw;
            note_write(midw);
            tag_enable = !en;
            s_tag_valid = !pv;
            s_tag_tci = ~ptci;
         end
         if (!pres && ($urandom % 4 == 0)) begin
            s_tvalid = 1'b0;
         end else begin
            pres = 1'b1;
            s_tvalid = 1'b1;
            s_tdata = pat(seed, i);
            s_tlast = (i == len - 1);
            if (i == 0) begin
               tag_enable = en;
               s_tag_valid = pv;
               s_tag_tci = ptci;
            end
         end
         #1;
         if (s_tvalid && s_tready) begin
            i++;
            pres = 1'b0;
         end
      end
      @(negedge clk);
      s_tvalid = 1'b0;
      s_tlast = 1'b0;
      cfg_wr_en = 1'b0;
   endtask

   // Sink: random backpressure
   always @(negedge clk) begin
      m_tready = sink_rand ? (($urandom % 3) != 0) : 1'b1;
   end

   // Monitor, compared every cycle away from the active edge
   bit         hold_pend = 1'b0;
   logic [7:0] hold_d = '0;
   always @(negedge clk) begin
      #1;
      if (rst_n && running) begin
         if (hold_pend) begin
            check(m_tvalid && m_tdata == hold_d, "R9", "held output byte", int'(m_tdata), int'(hold_d));
         end
         if (exp_t.size() > 0 && exp_t[0]) begin
            check(!s_tready, "R9", "s_tready while tag pending", int'(s_tready), 0);
         end
         hold_pend = m_tvalid && !m_tready;
         hold_d = m_tdata;
         if (m_tvalid && m_tready) begin
            if (exp_d.size() == 0) begin
               check(1'b0, "R3", "unexpected output byte", int'(m_tdata), 0);
            end else begin
               logic [7:0] ed;
               logic       el;
               logic       et;
               string      er;
               ed = exp_d.pop_front();
               el = exp_l.pop_front();
               et = exp_t.pop_front();
               er = exp_r.pop_front();
               check(m_tdata == ed, er, et ? "tag byte" : "frame byte", int'(m_tdata), int'(ed));
               check(m_tlast == el, "R12", "tlast", int'(m_tlast), int'(el));
            end
         end
      end
   end

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000 && !done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL R9 watchdog actual=hung expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(!m_tvalid, "R1", "m_tvalid after reset", int'(m_tvalid), 0);
      check(s_tready, "R1", "s_tready idle after reset", int'(s_tready), 1);
      running = 1'b1;
      sink_rand = 1'b1;

      // R1: register still zero, tag bytes are all zero
      send_frame(20, 1, 0, 16'h0, 8'h10, "R1", "R3", 0, 0);
      // R3 / R4: standard tag with PRI=5, CFI=0, VID=0x123
      cfg_write(32'h8100_A123);
      send_frame(30, 1, 0, 16'h0, 8'h21, "R4", "R3", 0, 0);
      // R2: tagging off
      send_frame(25, 0, 0, 16'h0, 8'h33, "R2", "R2", 0, 0);
      // R5: per-frame control word
      send_frame(18, 1, 1, 16'h3FFF, 8'h47, "R5", "R3", 0, 0);
      // R6: reserved type refused, previous value stays
      cfg_write(32'h8808_5555);
      send_frame(16, 1, 0, 16'h0, 8'h52, "R6", "R3", 0, 0);
      // R7 / R8: custom type, VID zero with PRI 7 and CFI 1
      cfg_write(32'h88A8_F000);
      send_frame(14, 1, 0, 16'h0, 8'h60, "R8", "R7", 0, 0);
      // R10: short frames untouched, R3 boundary at 13 bytes
      send_frame(5, 1, 0, 16'h0, 8'h71, "R10", "R10", 0, 0);
      send_frame(12, 1, 0, 16'h0, 8'h82, "R10", "R10", 0, 0);
      send_frame(13, 1, 0, 16'h0, 8'h93, "R3", "R3", 0, 0);
      send_frame(1, 1, 1, 16'h1234, 8'hA4, "R10", "R10", 0, 0);
      // R11: mid-frame register write and sideband flips have no effect
      send_frame(24, 1, 0, 16'h0ABC, 8'hB5, "R11", "R11", 1, 32'h9100_2BCD);
      send_frame(24, 0, 1, 16'h0ABC, 8'hC6, "R11", "R11", 1, 32'h8100_4001);
      send_frame(20, 1, 0, 16'h0, 8'hD7, "R11", "R3", 0, 0);
      // Mixed random frames
      for (int k = 0; k < 10; k++) begin
         send_frame(1 + int'($urandom % 40), bit'($urandom % 2), bit'($urandom % 2),
                    16'($urandom), int'($urandom % 256), "R4", "R3", 0, 0);
      end

      for (int w = 0; w < 1000 && exp_d.size() > 0; w++) @(negedge clk);
      check(exp_d.size() == 0, "R3", "bytes left undelivered", exp_d.size(), 0);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule